// File: doc/BRIEF.md
# Processor Status Word Flag Unit

This block holds the 16-bit status word of an 8/16-bit processor core. On each instruction it derives the four condition flags (carry, zero, sign, and a shared parity/overflow flag) from the ALU result. It stores each flag only when the decoder asserts that flag's own update bit. The carry flag also acts as a one-bit accumulator for bit-manipulation instructions. The parity/overflow flag reports even parity for logic operations and two's-complement overflow for arithmetic ones.

Software reads the packed word and writes it one byte at a time, with a separate enable for each byte. Interrupt or break entry saves the word by reading the packed output. The return sequence restores the whole word in one cycle through a dedicated restore path. Every result is registered, so the outputs change on the clock edge after the stimulus.

Top module: `psw_flag_unit`

## Requirements
- R1: Reset (active-low `rst_n`) clears every bit of `psw_o`, and the flag outputs read 0.
- R2: `wr_lo_i` loads `wr_data_i[7:0]` into `psw_o[7:0]`, and `wr_hi_i` loads `wr_data_i[15:12]` into `psw_o[15:12]`. The two enables act independently and may fire in the same cycle.
- R3: Bits 11..8 of `psw_o` always read 0, whatever is written or restored.
- R4: When the carry update bit (`flag_upd_i[0]`) is set, the carry flag (`psw_o[0]`) takes `alu_carry_i | alu_borrow_i` for class 0 (arithmetic) and class 1 (logic), and takes `bit_res_i` for class 2 (bit operation).
- R5: When the zero update bit (`flag_upd_i[1]`) is set, the zero flag (`psw_o[6]`) is 1 exactly when the result at the selected width (`word_op_i`=1: bits 15..0, else bits 7..0) is all zeros.
- R6: When the sign update bit (`flag_upd_i[2]`) is set, the sign flag (`psw_o[7]`) copies result bit 15 for a word operation and bit 7 for a byte operation.
- R7: When the P/V update bit (`flag_upd_i[3]`) is set for class 0 (arithmetic), the P/V flag (`psw_o[2]`) takes `alu_ovf_i`.
- R8: When the P/V update bit is set for class 1 (logic), the P/V flag is 1 when the number of one bits in the result at the selected width is even, and 0 when it is odd.
- R9: A flag whose update bit is clear keeps its value. With no update, write or restore, `psw_o` holds.
- R10: A byte write wins over a flag update for the bits it covers. A high-byte write alone does not block flag updates in the low byte.
- R11: `restore_i` loads the whole of `restore_data_i` (bits 11..8 forced to 0) and takes priority over byte writes and flag updates.
- R12: The packed layout is S=bit7, Z=bit6, RSS=bit5, AC=bit4, IE=bit3, P/V=bit2, LT=bit1, CY=bit0, UF=bit15, bank select=bits 14..12. `cy_o`, `z_o`, `s_o` and `pv_o` present the stored flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_res_i | input | 16 | ALU result |
| alu_carry_i | input | 1 | Carry out of the top bit at the selected width |
| alu_borrow_i | input | 1 | Borrow into the top bit at the selected width |
| alu_ovf_i | input | 1 | Two's-complement overflow or underflow |
| bit_res_i | input | 1 | Result of a bit-manipulation operation |
| word_op_i | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| op_class_i | input | 2 | 0 arithmetic, 1 logic, 2 bit operation |
| flag_upd_i | input | 4 | Update enables: bit0 CY, bit1 Z, bit2 S, bit3 P/V |
| wr_lo_i | input | 1 | Low byte write enable |
| wr_hi_i | input | 1 | High byte write enable |
| wr_data_i | input | 16 | Byte write data |
| restore_i | input | 1 | Full-word restore on return |
| restore_data_i | input | 16 | Word popped from the stack |
| psw_o | output | 16 | Packed status word |
| cy_o | output | 1 | Carry flag |
| z_o | output | 1 | Zero flag |
| s_o | output | 1 | Sign flag |
| pv_o | output | 1 | Parity/overflow flag |

## Verification
Every result of this block is due one clock edge after its stimulus: flag updates, byte writes and restores each pass through a single register stage. The bench applies each stimulus just after a rising edge and removes it just after the next one. It samples `psw_o` and the flag outputs one time unit after that edge, so each check sees exactly the effect of one stimulus. Hold and priority checks put conflicting or absent enables in the same cycle and read the packed word at that same sampling point.

// File: rtl/psw_pkg.sv
package psw_pkg;

    localparam int PSW_W  = 16;
    localparam int BYTE_W = 8;
    localparam int LANES  = PSW_W / BYTE_W;
    localparam int MASK_W = 4;

    // bit positions inside the packed word
    localparam int B_CY  = 0;
    localparam int B_LT  = 1;
    localparam int B_PV  = 2;
    localparam int B_IE  = 3;
    localparam int B_AC  = 4;
    localparam int B_RSS = 5;
    localparam int B_Z   = 6;
    localparam int B_S   = 7;

    // positions inside the per-flag update mask
    localparam int M_CY = 0;
    localparam int M_Z  = 1;
    localparam int M_S  = 2;
    localparam int M_PV = 3;

    typedef enum logic [1:0] {
        OPC_ARITH = 2'd0,
        OPC_LOGIC = 2'd1,
        OPC_BIT   = 2'd2
    } op_class_e;

    typedef struct packed {
        logic s;
        logic z;
        logic pv;
        logic cy;
    } cond_t;

endpackage

// File: rtl/psw_flag_calc.sv
module psw_flag_calc
    import psw_pkg::*;
(
    input  logic [PSW_W-1:0] res_i,
    input  logic             word_i,
    input  op_class_e        cls_i,
    input  logic             carry_i,
    input  logic             borrow_i,
    input  logic             ovf_i,
    input  logic             bit_res_i,
    output cond_t            cond_o
);

    logic [BYTE_W-1:0] res_lo;
    logic              top_bit;
    logic              is_zero;
    logic              odd_ones;

    always_comb begin
        res_lo   = res_i[BYTE_W-1:0];
        top_bit  = word_i ? res_i[PSW_W-1] : res_lo[BYTE_W-1];
        is_zero  = word_i ? (res_i == '0) : (res_lo == '0);
        odd_ones = word_i ? (^res_i) : (^res_lo);
    end

    always_comb begin
        cond_o.s = top_bit;
        cond_o.z = is_zero;
        unique case (cls_i)
            OPC_ARITH: begin
                cond_o.cy = carry_i | borrow_i;
                cond_o.pv = ovf_i;
            end
            OPC_LOGIC: begin
                cond_o.cy = carry_i | borrow_i;
                cond_o.pv = ~odd_ones;
            end
            OPC_BIT: begin
                cond_o.cy = bit_res_i;
                cond_o.pv = ovf_i;
            end
            default: begin
                cond_o.cy = 1'b0;
                cond_o.pv = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/psw_byte_lane.sv
module psw_byte_lane #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   LIVE = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_i,
    input  logic [W-1:0] ld_data_i,
    input  logic [W-1:0] upd_en_i,
    input  logic [W-1:0] upd_val_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] nxt;

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign nxt[b] = ld_i        ? ld_data_i[b] :
                        upd_en_i[b] ? upd_val_i[b] : q_o[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '0;
        end else begin
            q_o <= nxt & LIVE;
        end
    end

endmodule

// File: rtl/psw_flag_unit.sv
module psw_flag_unit
    import psw_pkg::*;
#(
    parameter logic [15:0] LIVE_BITS = 16'hF0FF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] alu_res_i,
    input  logic        alu_carry_i,
    input  logic        alu_borrow_i,
    input  logic        alu_ovf_i,
    input  logic        bit_res_i,
    input  logic        word_op_i,
    input  logic [1:0]  op_class_i,
    input  logic [3:0]  flag_upd_i,
    input  logic        wr_lo_i,
    input  logic        wr_hi_i,
    input  logic [15:0] wr_data_i,
    input  logic        restore_i,
    input  logic [15:0] restore_data_i,
    output logic [15:0] psw_o,
    output logic        cy_o,
    output logic        z_o,
    output logic        s_o,
    output logic        pv_o
);

    cond_t             cond;
    logic [PSW_W-1:0]  upd_en;
    logic [PSW_W-1:0]  upd_val;
    logic [LANES-1:0]  byte_wr;

    psw_flag_calc u_calc (
        .res_i     (alu_res_i),
        .word_i    (word_op_i),
        .cls_i     (op_class_e'(op_class_i)),
        .carry_i   (alu_carry_i),
        .borrow_i  (alu_borrow_i),
        .ovf_i     (alu_ovf_i),
        .bit_res_i (bit_res_i),
        .cond_o    (cond)
    );

    always_comb begin
        upd_en        = '0;
        upd_val       = '0;
        upd_en[B_CY]  = flag_upd_i[M_CY];
        upd_val[B_CY] = cond.cy;
        upd_en[B_Z]   = flag_upd_i[M_Z];
        upd_val[B_Z]  = cond.z;
        upd_en[B_S]   = flag_upd_i[M_S];
        upd_val[B_S]  = cond.s;
        upd_en[B_PV]  = flag_upd_i[M_PV];
        upd_val[B_PV] = cond.pv;
    end

    assign byte_wr = {wr_hi_i, wr_lo_i};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic              lane_ld;
        logic [BYTE_W-1:0] lane_data;

        assign lane_ld   = restore_i | byte_wr[l];
        assign lane_data = restore_i ? restore_data_i[l*BYTE_W +: BYTE_W]
                                     : wr_data_i[l*BYTE_W +: BYTE_W];

        psw_byte_lane #(
            .W    (BYTE_W),
            .LIVE (LIVE_BITS[l*BYTE_W +: BYTE_W])
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .ld_i      (lane_ld),
            .ld_data_i (lane_data),
            .upd_en_i  (upd_en[l*BYTE_W +: BYTE_W]),
            .upd_val_i (upd_val[l*BYTE_W +: BYTE_W]),
            .q_o       (psw_o[l*BYTE_W +: BYTE_W])
        );
    end

    assign cy_o = psw_o[B_CY];
    assign z_o  = psw_o[B_Z];
    assign s_o  = psw_o[B_S];
    assign pv_o = psw_o[B_PV];

endmodule

// File: rtl/psw_flag_unit_chk.sv
module psw_flag_unit_chk
    import psw_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] alu_res_i,
    input logic        bit_res_i,
    input logic        word_op_i,
    input logic [1:0]  op_class_i,
    input logic [3:0]  flag_upd_i,
    input logic        wr_lo_i,
    input logic        wr_hi_i,
    input logic [15:0] wr_data_i,
    input logic        restore_i,
    input logic [15:0] restore_data_i,
    input logic [15:0] psw_o,
    input logic        cy_o,
    input logic        z_o
);

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        psw_o[11:8] == 4'h0); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_i && !wr_lo_i && !wr_hi_i && flag_upd_i == 4'h0)
        |=> $stable(psw_o)); // R9

    AST_LO_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo_i && !restore_i) |=> psw_o[7:0] == $past(wr_data_i[7:0])); // R10

    AST_RESTORE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        restore_i |=> psw_o == ($past(restore_data_i) & 16'hF0FF)); // R11

    AST_BIT_ACCUM: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_upd_i[M_CY] && op_class_i == 2'(OPC_BIT) && !wr_lo_i && !restore_i)
        |=> cy_o == $past(bit_res_i)); // R4

    AST_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_upd_i[M_Z] && word_op_i && !wr_lo_i && !restore_i)
        |=> z_o == ($past(alu_res_i) == 16'h0000)); // R5

endmodule

bind psw_flag_unit psw_flag_unit_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .alu_res_i      (alu_res_i),
    .bit_res_i      (bit_res_i),
    .word_op_i      (word_op_i),
    .op_class_i     (op_class_i),
    .flag_upd_i     (flag_upd_i),
    .wr_lo_i        (wr_lo_i),
    .wr_hi_i        (wr_hi_i),
    .wr_data_i      (wr_data_i),
    .restore_i      (restore_i),
    .restore_data_i (restore_data_i),
    .psw_o          (psw_o),
    .cy_o           (cy_o),
    .z_o            (z_o)
);

// File: tb/psw_flag_unit_bench.sv
module psw_flag_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] alu_res_i = '0;
    logic        alu_carry_i = 1'b0;
    logic        alu_borrow_i = 1'b0;
    logic        alu_ovf_i = 1'b0;
    logic        bit_res_i = 1'b0;
    logic        word_op_i = 1'b0;
    logic [1:0]  op_class_i = '0;
    logic [3:0]  flag_upd_i = '0;
    logic        wr_lo_i = 1'b0;
    logic        wr_hi_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic        restore_i = 1'b0;
    logic [15:0] restore_data_i = '0;
    logic [15:0] psw_o;
    logic        cy_o, z_o, s_o, pv_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    localparam logic [1:0] ARITH = 2'd0;
    localparam logic [1:0] LOGIC = 2'd1;
    localparam logic [1:0] BITOP = 2'd2;

    always #4 clk = ~clk;

    psw_flag_unit u_psw_flag_unit (
        .clk(clk), .rst_n(rst_n),
        .alu_res_i(alu_res_i), .alu_carry_i(alu_carry_i),
        .alu_borrow_i(alu_borrow_i), .alu_ovf_i(alu_ovf_i),
        .bit_res_i(bit_res_i), .word_op_i(word_op_i),
        .op_class_i(op_class_i), .flag_upd_i(flag_upd_i),
        .wr_lo_i(wr_lo_i), .wr_hi_i(wr_hi_i), .wr_data_i(wr_data_i),
        .restore_i(restore_i), .restore_data_i(restore_data_i),
        .psw_o(psw_o), .cy_o(cy_o), .z_o(z_o), .s_o(s_o), .pv_o(pv_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        alu_res_i = '0; alu_carry_i = 0; alu_borrow_i = 0; alu_ovf_i = 0;
        bit_res_i = 0; word_op_i = 0; op_class_i = ARITH; flag_upd_i = '0;
        wr_lo_i = 0; wr_hi_i = 0; wr_data_i = '0;
        restore_i = 0; restore_data_i = '0;
    endtask

    task automatic set_alu(input logic [15:0] r, input logic c, input logic b,
                           input logic v, input logic w, input logic [1:0] cls,
                           input logic [3:0] m);
        alu_res_i = r; alu_carry_i = c; alu_borrow_i = b; alu_ovf_i = v;
        word_op_i = w; op_class_i = cls; flag_upd_i = m;
    endtask

    // stimulus is live for exactly one rising edge; sample 1 ns after it
    task automatic tick();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 psw", psw_o, 16'h0000);
        check("R1 flags", {12'h0, cy_o, z_o, s_o, pv_o}, 16'h0000);
        rst_n = 1'b1;
    endtask

    task automatic t_byte_write();
        wr_lo_i = 1; wr_hi_i = 1; wr_data_i = 16'hFF3A;
        tick();
        check("R2 R3 both bytes", psw_o, 16'hF03A);
    endtask

    task automatic t_arith_flags();
        set_alu(16'h0080, 1, 0, 1, 0, ARITH, 4'hF);
        tick();
        check("R4 R6 R7 byte arith", psw_o, 16'hF0BF);
        set_alu(16'h0000, 0, 0, 0, 1, ARITH, 4'hF);
        tick();
        check("R5 word zero", psw_o, 16'hF07A);
        set_alu(16'h1200, 0, 1, 0, 0, ARITH, 4'hF);
        tick();
        check("R4 R5 borrow byte zero", psw_o, 16'hF07B);
        set_alu(16'h8000, 0, 0, 0, 1, ARITH, 4'hF);
        tick();
        check("R6 word sign", psw_o, 16'hF0BA);
    endtask

    task automatic t_logic_parity();
        set_alu(16'h0103, 0, 0, 0, 0, LOGIC, 4'hF);
        tick();
        check("R8 byte even parity", psw_o, 16'hF03E);
        set_alu(16'h0103, 0, 0, 0, 1, LOGIC, 4'hF);
        tick();
        check("R8 word odd parity", psw_o, 16'hF03A);
    endtask

    task automatic t_bit_and_mask();
        set_alu(16'h0000, 0, 0, 0, 0, BITOP, 4'b0001);
        bit_res_i = 1;
        tick();
        check("R4 R9 bit accumulator", psw_o, 16'hF03B);
        set_alu(16'h0000, 1, 0, 1, 0, ARITH, 4'b0010);
        tick();
        check("R9 zero-only mask", psw_o, 16'hF07B);
    endtask

    task automatic t_priority();
        set_alu(16'h0000, 1, 0, 0, 0, ARITH, 4'hF);
        wr_lo_i = 1; wr_data_i = 16'h0055;
        tick();
        check("R10 low write beats update", psw_o, 16'hF055);
        set_alu(16'h0080, 1, 0, 1, 0, ARITH, 4'hF);
        wr_hi_i = 1; wr_data_i = 16'h2000;
        tick();
        check("R10 high write with update", psw_o, 16'h2095);
        check("R12 flag ports", {12'h0, cy_o, z_o, s_o, pv_o}, 16'h000B);
    endtask

    task automatic t_restore();
        set_alu(16'h0000, 1, 0, 1, 1, ARITH, 4'hF);
        wr_lo_i = 1; wr_data_i = 16'h0000;
        restore_i = 1; restore_data_i = 16'hABCD;
        tick();
        check("R11 R3 restore wins", psw_o, 16'hA0CD);
        tick();
        check("R9 idle hold", psw_o, 16'hA0CD);
    endtask

    initial begin
        idle();
        t_reset();
        @(posedge clk);
        #1;
        t_byte_write();
        t_arith_flags();
        t_logic_parity();
        t_bit_and_mask();
        t_priority();
        t_restore();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule